// File: doc/BRIEF.md
# Fractional Pacing Interval Timer

This block paces repeated conversions. It produces a single-cycle start tick whose spacing, averaged over time, is a fractional number of clock cycles. The requested period is one cycle plus a 16-bit whole part plus an 8-bit fraction counted in 1/256ths of a cycle. A down-counter times the whole part. A first-order delta-sigma accumulator spreads the fraction across periods, so each individual gap is either N or N+1 cycles and the long-run mean is exact.

A surrounding sequencer loads the divisor word with a write strobe and raises the run enable while paced conversions are wanted. It consumes the tick. Any divisor write restarts the timing from a clean state. A zero divisor gives a one-cycle period, so the tick is high on every cycle and the sequencer starts conversions as fast as it can accept them.

Top module: `pace_interval_timer`

## Requirements
- R1: After reset, `tick_o` is low and stays low until `run_en_i` is sampled high.
- R2: When a clock edge first samples `run_en_i` high (with `div_wr_i` low), `tick_o` is high in the cycle that follows that edge.
- R3: The gap from one tick to the next is WHOLE+1 cycles, plus one more cycle when the carry-out of an 8-bit accumulator is set. The accumulator starts at 0 and adds FRAC at each tick, and that tick's carry decides the gap that follows it.
- R4: Across any 256 consecutive tick periods started from a restart, the total length is exactly 256*(1+WHOLE)+FRAC cycles.
- R5: With WHOLE=0 and FRAC=0, `tick_o` is high on every cycle while running.
- R6: While `run_en_i` is low, no tick is produced and the count and accumulator return to their start values. Re-enabling therefore reproduces the same gap sequence as a fresh start.
- R7: A clock edge that samples `div_wr_i` high latches the new divisor and clears the timer. `tick_o` is low in the following cycle. If running continues, the first tick of the new sequence follows one cycle later.
- R8: `div_word_i` carries FRAC in bits 7:0 and WHOLE in bits 23:8.
- R9: With WHOLE of 1 or more, `tick_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_word_i | input | 24 | Divisor word: fraction in 7:0, whole part in 23:8 |
| div_wr_i | input | 1 | Divisor write strobe; latches the word and restarts timing |
| run_en_i | input | 1 | Pacing enable from the sequencer |
| tick_o | output | 1 | One-cycle conversion-start tick |

## Verification
The assertions check four local properties on every cycle. They check that a tick follows one cycle after enable and that the timer falls silent after a disable or a divisor write. They check that ticks never repeat back to back once the whole part is non-zero, and that they repeat on every cycle when the divisor is zero. The exact placement of each N+1 period and the exact 256-period total depend on the accumulator history, so only the bench scenarios can show them. The bench's tick-time scoreboard covers these, together with restart by a write in mid-run and the repeatability of the sequence after a pause.

// File: rtl/pace_pkg.sv
package pace_pkg;
   localparam int unsigned PACE_WHOLE_W_DEF = 16;
   localparam int unsigned PACE_FRAC_W_DEF  = 8;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } pace_phase_e;
endpackage

// File: rtl/pace_div_latch.sv
module pace_div_latch #(
   parameter int unsigned WHOLE_W = 16,
   parameter int unsigned FRAC_W  = 8,
   localparam int unsigned WORD_W = WHOLE_W + FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [WORD_W-1:0]  word_i,
   output logic [WHOLE_W-1:0] whole_o,
   output logic [FRAC_W-1:0]  frac_o
);
   // Field split: fraction occupies the low bits, whole part above it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         whole_o <= '0;
         frac_o  <= '0;
      end else if (wr_i) begin
         whole_o <= word_i[WORD_W-1:FRAC_W];
         frac_o  <= word_i[FRAC_W-1:0];
      end
   end
endmodule

// File: rtl/pace_dsm_accum.sv
module pace_dsm_accum #(
   parameter int unsigned FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              carry_o
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
   assign carry_o = step_i & sum[FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) acc_q <= '0;
      else if (step_i)     acc_q <= sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/pace_down_counter.sv
module pace_down_counter #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   assign zero_o = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) cnt_q <= '0;
      else if (load_i)     cnt_q <= load_val_i;
      else if (!zero_o)    cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/pace_interval_timer.sv
module pace_interval_timer
   import pace_pkg::*;
#(
   parameter int unsigned WHOLE_W = PACE_WHOLE_W_DEF,
   parameter int unsigned FRAC_W  = PACE_FRAC_W_DEF,
   localparam int unsigned WORD_W = WHOLE_W + FRAC_W,
   localparam int unsigned CNT_W  = WHOLE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] div_word_i,
   input  logic              div_wr_i,
   input  logic              run_en_i,
   output logic              tick_o
);
   // Elaboration-time parameter checks
   generate
      if (WHOLE_W < 1 || WHOLE_W > 31) begin : g_bad_whole
         $error("pace_interval_timer: WHOLE_W must be 1..31");
      end
      if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac
         $error("pace_interval_timer: FRAC_W must be 1..16");
      end
   endgenerate

   logic [WHOLE_W-1:0] whole_q;
   logic [FRAC_W-1:0]  frac_q;
   pace_phase_e        phase_q;
   logic               restart;
   logic               step;
   logic               carry;
   logic               cnt_zero;
   logic [CNT_W-1:0]   reload;

   pace_div_latch #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (div_wr_i),
      .word_i  (div_word_i),
      .whole_o (whole_q),
      .frac_o  (frac_q)
   );

   assign restart = !run_en_i || div_wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n)       phase_q <= PH_IDLE;
      else if (restart) phase_q <= PH_IDLE;
      else              phase_q <= PH_RUN;
   end

   assign tick_o = (phase_q == PH_RUN) && cnt_zero;
   assign step   = tick_o && !restart;

   pace_dsm_accum #(.FRAC_W(FRAC_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (restart),
      .step_i  (step),
      .frac_i  (frac_q),
      .carry_o (carry)
   );

   assign reload = CNT_W'(whole_q) + CNT_W'(carry);

   pace_down_counter #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (restart),
      .load_i     (step),
      .load_val_i (reload),
      .zero_o     (cnt_zero)
   );

   // Guarding properties
   assert_first_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run_en_i) && !div_wr_i) |=> tick_o);

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en_i |=> !tick_o);

   assert_write_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr_i |=> !tick_o);

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && run_en_i && !div_wr_i && whole_q != '0) |=> !tick_o);

   assert_every_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && run_en_i && !div_wr_i && whole_q == '0 && frac_q == '0) |=> tick_o);
endmodule

// File: tb/pace_interval_timer_test.sv
module pace_interval_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] div_word = '0;
   logic        div_wr = 1'b0;
   logic        run_en = 1'b0;
   logic        tick;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   string cur_req = "R1";
   int exp_q[$];
   int obs_q[$];

   always #5 clk = ~clk;

   pace_interval_timer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_word_i (div_word),
      .div_wr_i   (div_wr),
      .run_en_i   (run_en),
      .tick_o     (tick)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: every observed tick is matched to the next expected tick time
   always @(negedge clk) begin
      if (rst_n && tick) begin
         obs_q.push_back(cyc);
         compared++;
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL %s: tick at cycle %0d, expected none", cur_req, cyc);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != cyc) begin
               mismatched++;
               $display("FAIL %s: tick at cycle %0d, expected %0d", cur_req, cyc, e);
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int expv);
      compared++;
      if (act != expv) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   // Driver side: push tick times below limit, return the next tick time
   task automatic push_ticks(input int start, input int whole, input int frac,
                             input int limit, input int nmax, output int next_t);
      int t = start;
      int acc = 0;
      for (int i = 0; i < nmax && t < limit; i++) begin
         int s;
         exp_q.push_back(t);
         s = acc + frac;
         acc = s % 256;
         t = t + whole + 1 + (s / 256);
      end
      next_t = t;
   endtask

   task automatic write_div(input int whole, input int frac);
      @(negedge clk);
      div_word = {whole[15:0], frac[7:0]};
      div_wr = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
   endtask

   // Enable, expect n ticks, then disable just before the next one
   task automatic run_for(input int whole, input int frac, input int n);
      int start;
      int stop;
      run_en = 1'b1;
      start = cyc + 1;
      push_ticks(start, whole, frac, 32'h7fffffff, n, stop);
      while (cyc != stop - 1) @(negedge clk);
      run_en = 1'b0;
      repeat (4) @(negedge clk);
      check({cur_req, " leftover"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int n_before;
      int w;
      int dummy;
      int start;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 tick in reset", int'(tick), 0);
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge clk);
         check("R1 tick after reset", int'(tick), 0);
      end

      // R2 and R3: first tick timing and dithered gaps
      cur_req = "R2/R3";
      write_div(3, 100);
      run_for(3, 100, 12);

      // R8: field positions, half fraction alternates gaps 2 and 3
      cur_req = "R8";
      write_div(1, 128);
      run_for(1, 128, 10);

      // R9: whole part 1 with near-full fraction
      cur_req = "R9";
      write_div(1, 255);
      run_for(1, 255, 12);

      // R3: long whole part
      cur_req = "R3";
      write_div(300, 7);
      run_for(300, 7, 4);

      // R5: zero divisor gives a tick every cycle
      cur_req = "R5";
      write_div(0, 0);
      run_for(0, 0, 20);

      // R4: exact total over 256 periods
      cur_req = "R4";
      write_div(2, 77);
      obs_q.delete();
      run_for(2, 77, 257);
      check("R4 obs count", obs_q.size(), 257);
      if (obs_q.size() == 257)
         check("R4 256-period total", obs_q[256] - obs_q[0], 256 * 3 + 77);

      // R6: idle with a write while disabled produces no tick
      cur_req = "R6";
      n_before = obs_q.size();
      write_div(2, 200);
      repeat (30) @(negedge clk);
      check("R6 no tick while idle", obs_q.size() - n_before, 0);
      // R6: re-enable without write reproduces a fresh sequence, twice
      run_for(2, 200, 9);
      repeat (7) @(negedge clk);
      run_for(2, 200, 9);

      // R7: divisor write while running restarts timing
      cur_req = "R7";
      write_div(3, 100);
      run_en = 1'b1;
      start = cyc + 1;
      w = start + 23;
      push_ticks(start, 3, 100, w, 1000, dummy);
      while (cyc != w - 1) @(negedge clk);
      div_word = {16'd5, 8'd200};
      div_wr = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
      check("R7 no tick after write edge", int'(tick), 0);
      push_ticks(w + 1, 5, 200, 32'h7fffffff, 10, dummy);
      while (cyc != dummy - 1) @(negedge clk);
      run_en = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 leftover", exp_q.size(), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule